// File: doc/BRIEF.md
# Cycle Trace Ring Buffer

The block captures one 256-bit trace sample on every clock into an on-chip RAM that is used as a ring. A write pointer, counted in entries, moves forward by one for each sample that is stored and wraps back to zero after the last entry. Software or a debugger reads the captured history back in 64-bit pieces.

Two access ports serve the buffer, one for the processor and one for the debug bus. The two ports work the same way. Each port has an address register and a data register, and a request names one of them. A read of the address register returns the write pointer in the upper word. The buffer length is ORed into that word, so the length can be found from its highest set bit. The lower word holds the port's freeze bit in bit 31 and its read pointer, counted in doublewords, in bits 30:0. A read of the data register returns the doubleword at the read pointer and then steps the pointer forward. Capture stops while either port has its freeze bit set, which keeps the contents stable for readout.

Each port runs a small state machine with four states. `P_IDLE` means no response is pending. `P_ADDR_RSP` means an address-register read is being answered. `P_DATA_RSP` means a data-register read is being answered. `P_WR_RSP` means a write is being acknowledged. On every clock the machine moves to the state selected by that cycle's request: a write goes to `P_WR_RSP`, a data read to `P_DATA_RSP`, an address read to `P_ADDR_RSP`, and no request to `P_IDLE`.

Top module: `trace_ring`

## Requirements
- R1: After reset the write pointer, both read pointers and both freeze bits are zero, and no acknowledge is asserted. A first address read returns upper word DEPTH and lower word 0.
- R2: While not frozen, the entry presented on `trace_in` is stored at the write pointer on every clock. The pointer then advances by one modulo DEPTH.
- R3: Bits 63:32 of an address read equal the write pointer ORed with DEPTH. DEPTH is a power of two.
- R4: A data read returns 64 bits of entry `(rptr >> 2) mod DEPTH`. `rptr[1:0]` selects the quarter, and quarter 0 is bits 63:0. The read pointer then increases by one.
- R5: An address write loads the read pointer from `wdata[30:0]` and the freeze bit from `wdata[31]`. `wdata[63:32]` is ignored.
- R6: No entry is stored while the processor-port freeze bit, the debug-port freeze bit, or both are set. The state set at one clock edge governs capture from the next edge onward.
- R7: Every request is acknowledged exactly one cycle later with a one-cycle `ack`. Requests may arrive back to back on consecutive cycles.
- R8: A write to the data register changes nothing. It is acknowledged with read data 0.
- R9: The two ports keep separate read pointers. Reads on one port never move the other port's pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_in | input | 256 | Trace sample for this cycle |
| cpu_req | input | 1 | Processor port request strobe |
| cpu_is_data | input | 1 | 1 selects the data register, 0 the address register |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_wdata | input | 64 | Processor port write value |
| cpu_ack | output | 1 | Processor port response strobe |
| cpu_rdata | output | 64 | Processor port read value |
| dbg_req | input | 1 | Debug port request strobe |
| dbg_is_data | input | 1 | 1 selects the data register, 0 the address register |
| dbg_we | input | 1 | 1 for a write, 0 for a read |
| dbg_wdata | input | 64 | Debug port write value |
| dbg_ack | output | 1 | Debug port response strobe |
| dbg_rdata | output | 64 | Debug port read value |

## Verification
Every response appears one cycle after its request is sampled. The bench model therefore computes each expected value at the same rising edge at which the design samples the request, and queues it. The monitor checks `ack` and read data at the following falling edge. Capture and freeze changes take effect at the edge after the request. For this reason the model first evaluates reads against the pre-edge buffer and pointer state, then stores the sample under the old freeze state, and only then applies the register writes.

// File: rtl/trace_pkg.sv
package trace_pkg;
    localparam int DW = 64;

    typedef enum logic [1:0] {
        P_IDLE,
        P_ADDR_RSP,
        P_DATA_RSP,
        P_WR_RSP
    } port_state_e;
endpackage

// File: rtl/trace_ram.sv
module trace_ram #(
    parameter int DEPTH   = 2048,
    parameter int ENTRY_W = 256,
    parameter int NRD     = 2,
    parameter int AW      = $clog2(DEPTH)
) (
    input  logic                            clk,
    input  logic                            wen,
    input  logic [AW-1:0]                   waddr,
    input  logic [ENTRY_W-1:0]              wdata,
    input  logic [NRD-1:0]                  ren,
    input  logic [NRD-1:0][AW-1:0]          raddr,
    output logic [NRD-1:0][ENTRY_W-1:0]     rdata
);
    logic [ENTRY_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wen) mem[waddr] <= wdata;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        logic [ENTRY_W-1:0] q;
        always_ff @(posedge clk) begin
            if (ren[g]) q <= mem[raddr[g]];
        end
        assign rdata[g] = q;
    end
endmodule

// File: rtl/trace_port.sv
module trace_port
    import trace_pkg::*;
#(
    parameter int ENTRY_W = 256,
    parameter int AW      = 11,
    parameter int QB      = $clog2(ENTRY_W / DW)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               is_data,
    input  logic               we,
    input  logic [DW-1:0]      wdata,
    input  logic [31:0]        wptr_word,
    input  logic [ENTRY_W-1:0] ram_q,
    output logic               ren,
    output logic [AW-1:0]      ridx,
    output logic               frz,
    output logic               ack,
    output logic [DW-1:0]      rdata
);
    port_state_e    state, nxt;
    logic [30:0]    rptr;
    logic [DW-1:0]  addr_q;
    logic [QB-1:0]  qsel_q;
    logic           unused_hi;

    assign unused_hi = ^wdata[63:32];
    assign ren  = req && is_data && !we;
    assign ridx = rptr[QB +: AW];

    always_comb begin
        nxt = P_IDLE;
        if (req) begin
            if (we)           nxt = P_WR_RSP;
            else if (is_data) nxt = P_DATA_RSP;
            else              nxt = P_ADDR_RSP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= P_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr   <= '0;
            frz    <= 1'b0;
            addr_q <= '0;
            qsel_q <= '0;
        end else if (req) begin
            if (!we && !is_data) begin
                addr_q <= {wptr_word, frz, rptr};
            end else if (!we && is_data) begin
                rptr   <= rptr + 31'd1;
                qsel_q <= rptr[QB-1:0];
            end else if (we && !is_data) begin
                frz  <= wdata[31];
                rptr <= wdata[30:0];
            end
        end
    end

    always_comb begin
        ack   = (state != P_IDLE);
        rdata = '0;
        unique case (state)
            P_ADDR_RSP: rdata = addr_q;
            P_DATA_RSP: rdata = ram_q[{qsel_q, 6'b0} +: DW];
            P_WR_RSP:   rdata = '0;
            P_IDLE:     rdata = '0;
        endcase
    end

    AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> ack); // R7
    AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !ack); // R7
    AST_RPTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (req && is_data && !we) |=> (rptr == $past(rptr) + 31'd1)); // R4
    AST_DATA_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (req && is_data && we) |=> ($stable(rptr) && $stable(frz))); // R8
    AST_FRZ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !is_data && we) |=> (frz == $past(wdata[31]))); // R5
endmodule

// File: rtl/trace_ring.sv
module trace_ring
    import trace_pkg::*;
#(
    parameter int DEPTH   = 2048,
    parameter int ENTRY_W = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRY_W-1:0] trace_in,
    input  logic               cpu_req,
    input  logic               cpu_is_data,
    input  logic               cpu_we,
    input  logic [63:0]        cpu_wdata,
    output logic               cpu_ack,
    output logic [63:0]        cpu_rdata,
    input  logic               dbg_req,
    input  logic               dbg_is_data,
    input  logic               dbg_we,
    input  logic [63:0]        dbg_wdata,
    output logic               dbg_ack,
    output logic [63:0]        dbg_rdata
);
    localparam int          NPORT    = 2;
    localparam int          AW       = $clog2(DEPTH);
    localparam logic [31:0] LEN_WORD = 32'(DEPTH);

    logic [AW-1:0]                   wptr;
    logic                            frozen;
    logic [31:0]                     wptr_word;
    logic [NPORT-1:0]                req_v, isd_v, we_v, ren_v, frz_v, ack_v;
    logic [NPORT-1:0][DW-1:0]        wd_v, rd_v;
    logic [NPORT-1:0][AW-1:0]        ridx_v;
    logic [NPORT-1:0][ENTRY_W-1:0]   q_v;

    assign req_v = {dbg_req, cpu_req};
    assign isd_v = {dbg_is_data, cpu_is_data};
    assign we_v  = {dbg_we, cpu_we};
    assign wd_v  = {dbg_wdata, cpu_wdata};

    assign frozen    = |frz_v;
    assign wptr_word = LEN_WORD | 32'(wptr);

    always_ff @(posedge clk) begin
        if (!rst_n)       wptr <= '0;
        else if (!frozen) wptr <= wptr + 1'b1;
    end

    trace_ram #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .NRD(NPORT), .AW(AW)) u_ram (
        .clk   (clk),
        .wen   (!frozen && rst_n),
        .waddr (wptr),
        .wdata (trace_in),
        .ren   (ren_v),
        .raddr (ridx_v),
        .rdata (q_v)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        trace_port #(.ENTRY_W(ENTRY_W), .AW(AW)) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (req_v[p]),
            .is_data   (isd_v[p]),
            .we        (we_v[p]),
            .wdata     (wd_v[p]),
            .wptr_word (wptr_word),
            .ram_q     (q_v[p]),
            .ren       (ren_v[p]),
            .ridx      (ridx_v[p]),
            .frz       (frz_v[p]),
            .ack       (ack_v[p]),
            .rdata     (rd_v[p])
        );
    end

    assign cpu_ack   = ack_v[0];
    assign cpu_rdata = rd_v[0];
    assign dbg_ack   = ack_v[1];
    assign dbg_rdata = rd_v[1];

    AST_FREEZE_HOLDS_WPTR: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> $stable(wptr)); // R6
    AST_WPTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        !frozen |=> (wptr == AW'($past(wptr) + 1'b1))); // R2
endmodule

// File: tb/trace_ring_tb.sv
module trace_ring_tb;
    localparam int DEPTH = 16;
    localparam int EW    = 256;

    typedef struct {
        logic [63:0] v;
        string       tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [EW-1:0] trace_in;
    logic          req   [2];
    logic          isd   [2];
    logic          we    [2];
    logic [63:0]   wd    [2];
    string         tg    [2];
    logic          ack_o [2];
    logic [63:0]   rd_o  [2];

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    int seq   = 0;

    item_t q0[$];
    item_t q1[$];

    logic [EW-1:0] mmem [DEPTH];
    int            mwp;
    logic          mfrz [2];
    logic [30:0]   mrp  [2];

    always #5 clk = ~clk;

    trace_ring #(.DEPTH(DEPTH), .ENTRY_W(EW)) u_dut (
        .clk(clk), .rst_n(rst_n), .trace_in(trace_in),
        .cpu_req(req[0]), .cpu_is_data(isd[0]), .cpu_we(we[0]), .cpu_wdata(wd[0]),
        .cpu_ack(ack_o[0]), .cpu_rdata(rd_o[0]),
        .dbg_req(req[1]), .dbg_is_data(isd[1]), .dbg_we(we[1]), .dbg_wdata(wd[1]),
        .dbg_ack(ack_o[1]), .dbg_rdata(rd_o[1])
    );

    function automatic logic [EW-1:0] pat(int s);
        logic [EW-1:0] r;
        for (int k = 0; k < 4; k++) r[k*64 +: 64] = {16'hC0DE, 8'(k), 8'h5A, 32'(s)};
        return r;
    endfunction

    always @(negedge clk) begin
        seq++;
        trace_in <= pat(seq);
    end

    // Scoreboard model: expectations from pre-edge state, then capture, then updates
    always @(posedge clk) begin
        item_t it;
        cyc++;
        if (!rst_n) begin
            mwp = 0;
            for (int p = 0; p < 2; p++) begin mfrz[p] = 1'b0; mrp[p] = '0; end
        end else begin
            for (int p = 0; p < 2; p++) begin
                if (req[p]) begin
                    it.tag = tg[p];
                    if (we[p]) it.v = 64'd0;
                    else if (isd[p]) it.v = mmem[(int'(mrp[p]) >> 2) % DEPTH][int'(mrp[p][1:0])*64 +: 64];
                    else it.v = {(32'(mwp) | 32'(DEPTH)), mfrz[p], mrp[p]};
                    if (p == 0) q0.push_back(it); else q1.push_back(it);
                end
            end
            if (!(mfrz[0] || mfrz[1])) begin
                mmem[mwp] = trace_in;
                mwp = (mwp + 1) % DEPTH;
            end
            for (int p = 0; p < 2; p++) begin
                if (req[p] && !we[p] && isd[p]) mrp[p] = mrp[p] + 31'd1;
                if (req[p] && we[p] && !isd[p]) begin
                    mfrz[p] = wd[p][31];
                    mrp[p]  = wd[p][30:0];
                end
            end
        end
    end

    task automatic mon(int p);
        item_t it;
        int    sz;
        sz = (p == 0) ? q0.size() : q1.size();
        if (sz == 0) begin
            if (ack_o[p]) begin
                n_cmp++; n_bad++;
                $display("FAIL R7 port%0d: ack=1 expected ack=0", p);
            end
        end else begin
            it = (p == 0) ? q0.pop_front() : q1.pop_front();
            n_cmp++;
            if (!ack_o[p] || rd_o[p] !== it.v) begin
                n_bad++;
                $display("FAIL %s port%0d: ack=%0b data=%h expected ack=1 data=%h",
                         it.tag, p, ack_o[p], rd_o[p], it.v);
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            mon(0);
            mon(1);
        end
    end

    task automatic issue(int p, logic d, logic w, logic [63:0] v, string t);
        req[p] = 1'b1; isd[p] = d; we[p] = w; wd[p] = v; tg[p] = t;
    endtask

    task automatic step();
        @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            req[p] = 1'b0; isd[p] = 1'b0; we[p] = 1'b0; wd[p] = '0;
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: cycles=%0d expected < 20000", cyc);
            finish_run();
        end
    end

    initial begin
        trace_in = pat(0);
        for (int p = 0; p < 2; p++) begin
            req[p] = 1'b0; isd[p] = 1'b0; we[p] = 1'b0; wd[p] = '0; tg[p] = "";
        end
        repeat (3) @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            n_cmp++;
            if (ack_o[p] !== 1'b0) begin
                n_bad++;
                $display("FAIL R1 port%0d reset ack=%b expected 0", p, ack_o[p]);
            end
        end
        rst_n = 1'b1;
        issue(0, 0, 0, 0, "R1"); issue(1, 0, 0, 0, "R1"); step();
        repeat (40) step();                                    // R2 wrap
        issue(0, 0, 0, 0, "R3"); step();
        issue(0, 0, 1, {32'hFFFF_FFFF, 32'h8000_0000}, "R5"); step();
        repeat (5) step();
        issue(0, 0, 0, 0, "R6"); step();
        repeat (3) step();
        issue(0, 0, 0, 0, "R6"); step();
        for (int i = 0; i < 8; i++) begin issue(0, 1, 0, 0, "R4"); step(); end  // R7 back to back
        issue(1, 0, 1, {32'h1234_5678, 32'h0000_0005}, "R5"); step();
        issue(1, 0, 0, 0, "R5"); step();
        for (int i = 0; i < 3; i++) begin issue(1, 1, 0, 0, "R9"); step(); end
        issue(0, 0, 0, 0, "R9"); step();
        issue(1, 0, 1, 64'h0000_0000_8000_0008, "R6"); step();
        issue(0, 0, 1, 64'd0, "R6"); step();
        repeat (4) step();
        issue(0, 0, 0, 0, "R6"); step();
        issue(1, 0, 1, 64'd0, "R2"); step();
        repeat (10) step();
        issue(1, 0, 1, 64'h0000_0000_8000_003F, "R4"); step();
        issue(1, 1, 0, 0, "R4"); step();
        issue(1, 1, 0, 0, "R4"); step();
        issue(0, 1, 1, 64'hDEAD_BEEF_0000_0003, "R8"); step();
        issue(0, 0, 0, 0, "R8"); step();
        issue(0, 1, 0, 0, "R9"); issue(1, 1, 0, 0, "R9"); step();
        issue(0, 0, 0, 0, "R9"); issue(1, 0, 0, 0, "R9"); step();
        repeat (3) step();
        finish_run();
    end
endmodule